// File: doc/BRIEF.md
# Flash Command Register Decoder

This block is the command interpreter on the device side of a byte-wide, electrically erasable memory. It samples the active-low chip-enable, output-enable and write-enable strobes into a system clock and finds the write-enable edges. It takes the address on the falling edge of a qualified write and the command or data byte on the rising edge. From the command bytes it tracks the current operating mode. That mode selects where read data comes from and when the erase and program operations start and stop.

Destructive operations need two writes: a set-up byte followed by a matching execute write. They run only while the high-programming-voltage indicator is asserted. A small register-file array stands in for the cell matrix. Erase sets every byte to FFH. Programming can only clear bits, so the stored byte becomes the old byte AND the written data. The external address is 18 bits wide, and the array model decodes its low `MEM_AW` bits (16 bytes by default).

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block is in read-array mode, `data_oe_o`, `erase_active_o` and `prog_active_o` are low, and every array byte reads FFH.
- R2: In read-array mode, with chip-enable and output-enable both low, `data_oe_o` is high and `data_o` is the array byte at `addr_i[MEM_AW-1:0]`. If either strobe is high, `data_oe_o` is low and `data_o` is 00H.
- R3: Writing 90H selects identifier mode. Reads at address 0 return 89H, reads at address 1 return BDH, and reads at any other address return 00H. The mode persists over any number of reads until another byte is written.
- R4: Writing 20H and then 20H again, with the voltage indicator high, sets `erase_active_o` at the rising edge of the second write and turns every array byte into FFH.
- R5: Writing A0H clears `erase_active_o` at the rising edge of that write and enters erase verify. From then on, reads return the array byte at the address present on the falling edge of the A0H write, whatever address is being read.
- R6: Writing 40H and then a data byte D at address A, with the voltage indicator high, sets `prog_active_o` and replaces the byte at A with (old byte AND D).
- R7: Writing C0H clears `prog_active_o` and enters program verify. Reads then return the byte at the last programmed address; the address of the C0H write is not latched.
- R8: If the voltage indicator is low at the execute write of an erase or program sequence, no operation starts, the array is unchanged, and the block returns to read-array mode.
- R9: A byte outside {90H, 20H, 40H, A0H, C0H} written in an idle mode, a set-up 20H followed by any byte other than 20H, or an active erase or program ended by any byte other than its verify opcode, returns the block to read-array mode. Any active operation stops.
- R10: Write-enable pulses while chip-enable is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 18 | Byte address |
| data_i | input | 8 | Write data / command byte |
| vpp_hi_i | input | 1 | High programming voltage present |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data bus drive enable (low = high impedance) |
| erase_active_o | output | 1 | Erase operation in progress |
| prog_active_o | output | 1 | Program operation in progress |

## Verification
Assertions check several rules on every cycle. An operation can start only out of its own set-up mode, and only while the voltage indicator is high. Mode changes happen only on a qualified rising write edge. The verify address stays stable during program verify. After a program the stored byte never has a 1 where the data had a 0, and after an erase the array is filled with FFH. Some behaviour only the bench scenarios can show. Those scenarios cover the full 16-byte array, the order of command sequences, identifier persistence, verify reads that ignore the live address, rejected and aborted sequences, and writes issued while deselected.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    M_READ, M_IDENT, M_ESETUP, M_ERASE, M_EVERIFY, M_PSETUP, M_PROG, M_PVERIFY
  } mode_e;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_IDENT, SRC_LATCHED} rd_src_e;

  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_EVERIFY = 8'hA0;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_PVERIFY = 8'hC0;
  localparam logic [7:0] ID_MFR     = 8'h89;
  localparam logic [7:0] ID_DEV     = 8'hBD;
  localparam logic [7:0] ERASED_VAL = 8'hFF;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic rd_en_o,
  output logic wr_fall_o,
  output logic wr_rise_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0] raw;
  logic [2:0] sync_q [SYNC_STAGES];
  logic       we_prev_q;
  logic       ce_s, oe_s, we_s;

  assign raw = {ce_ni, oe_ni, we_ni};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
      we_prev_q <= 1'b1;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      we_prev_q <= sync_q[LAST][0];
    end
  end

  assign ce_s = ~sync_q[LAST][2];
  assign oe_s = ~sync_q[LAST][1];
  assign we_s = sync_q[LAST][0];

  assign rd_en_o   = ce_s & oe_s;
  assign wr_fall_o = ce_s & we_prev_q & ~we_s;
  assign wr_rise_o = ce_s & ~we_prev_q & we_s;
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_fall_i,
  input  logic              wr_rise_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vpp_hi_i,
  output mode_e             mode_o,
  output rd_src_e           rd_src_o,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic              erase_go_o,
  output logic              prog_go_o,
  output logic [ADDR_W-1:0] prog_addr_o
);
  mode_e             mode_q, mode_d;
  logic [ADDR_W-1:0] fall_addr_q, verify_addr_q, prog_addr_q;
  logic              erase_go, prog_go;

  function automatic mode_e decode_idle(input logic [DATA_W-1:0] b);
    case (b)
      OP_IDENT:   return M_IDENT;
      OP_ERASE:   return M_ESETUP;
      OP_PROG:    return M_PSETUP;
      OP_EVERIFY: return M_EVERIFY;
      OP_PVERIFY: return M_PVERIFY;
      default:    return M_READ;
    endcase
  endfunction

  always_comb begin
    mode_d   = mode_q;
    erase_go = 1'b0;
    prog_go  = 1'b0;
    if (wr_rise_i) begin
      case (mode_q)
        M_ESETUP: begin
          if (data_i == OP_ERASE && vpp_hi_i) begin
            mode_d   = M_ERASE;
            erase_go = 1'b1;
          end else begin
            mode_d = M_READ;
          end
        end
        M_ERASE:  mode_d = (data_i == OP_EVERIFY) ? M_EVERIFY : M_READ;
        M_PSETUP: begin
          if (vpp_hi_i) begin
            mode_d  = M_PROG;
            prog_go = 1'b1;
          end else begin
            mode_d = M_READ;
          end
        end
        M_PROG:   mode_d = (data_i == OP_PVERIFY) ? M_PVERIFY : M_READ;
        default:  mode_d = decode_idle(data_i);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q        <= M_READ;
      fall_addr_q   <= '0;
      verify_addr_q <= '0;
      prog_addr_q   <= '0;
    end else begin
      mode_q <= mode_d;
      if (wr_fall_i) fall_addr_q <= addr_i;
      if (wr_rise_i && mode_d == M_EVERIFY) verify_addr_q <= fall_addr_q;
      if (prog_go) prog_addr_q <= fall_addr_q;
    end
  end

  always_comb begin
    case (mode_q)
      M_IDENT:   rd_src_o = SRC_IDENT;
      M_EVERIFY,
      M_PVERIFY: rd_src_o = SRC_LATCHED;
      default:   rd_src_o = SRC_ARRAY;
    endcase
  end

  assign lat_addr_o  = (mode_q == M_PVERIFY) ? prog_addr_q : verify_addr_q;
  assign mode_o      = mode_q;
  assign erase_go_o  = erase_go;
  assign prog_go_o   = prog_go;
  assign prog_addr_o = fall_addr_q;

  // R4 R8
  erase_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q == M_ERASE) |-> ($past(mode_q) == M_ESETUP && $past(vpp_hi_i)));

  // R6 R8
  prog_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q == M_PROG) |-> ($past(mode_q) == M_PSETUP && $past(vpp_hi_i)));

  // R7
  pverify_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_PVERIFY && $past(mode_q) == M_PVERIFY) |-> $stable(prog_addr_q));

  // R9 R10
  mode_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(wr_rise_i));
endmodule

// File: rtl/byte_array.sv
module byte_array #(
  parameter int MEM_AW = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [MEM_AW-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [MEM_AW-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
    end
  end

  assign rd_data_a_o = mem_q[rd_addr_a_i];
  assign rd_data_b_o = mem_q[rd_addr_b_i];

  // R4
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (mem_q[0] == '1 && mem_q[DEPTH-1] == '1));

  // R6
  prog_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) && !$past(clr_i) |->
      ((mem_q[$past(wr_addr_i)] & ~$past(wr_data_i)) == '0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int MEM_AW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vpp_hi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              erase_active_o,
  output logic              prog_active_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              rd_en, wr_fall, wr_rise;
  mode_e             mode;
  rd_src_e           rd_src;
  logic [ADDR_W-1:0] lat_addr, prog_addr;
  logic              erase_go, prog_go;
  logic [DATA_W-1:0] rd_live, rd_lat, id_byte, rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      addr_q <= addr_i;
      din_q  <= data_i;
    end
  end

  strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .rd_en_o(rd_en), .wr_fall_o(wr_fall), .wr_rise_o(wr_rise)
  );

  cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .wr_fall_i(wr_fall), .wr_rise_i(wr_rise),
    .addr_i(addr_q), .data_i(din_q), .vpp_hi_i,
    .mode_o(mode), .rd_src_o(rd_src), .lat_addr_o(lat_addr),
    .erase_go_o(erase_go), .prog_go_o(prog_go), .prog_addr_o(prog_addr)
  );

  byte_array #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .clr_i(erase_go), .wr_en_i(prog_go),
    .wr_addr_i(prog_addr[MEM_AW-1:0]), .wr_data_i(din_q),
    .rd_addr_a_i(addr_q[MEM_AW-1:0]), .rd_data_a_o(rd_live),
    .rd_addr_b_i(lat_addr[MEM_AW-1:0]), .rd_data_b_o(rd_lat)
  );

  always_comb begin
    if (addr_q == ADDR_W'(0))      id_byte = ID_MFR;
    else if (addr_q == ADDR_W'(1)) id_byte = ID_DEV;
    else                           id_byte = '0;
  end

  always_comb begin
    case (rd_src)
      SRC_IDENT:   rd_mux = id_byte;
      SRC_LATCHED: rd_mux = rd_lat;
      default:     rd_mux = rd_live;
    endcase
  end

  assign data_o         = rd_en ? rd_mux : '0;
  assign data_oe_o      = rd_en;
  assign erase_active_o = (mode == M_ERASE);
  assign prog_active_o  = (mode == M_PROG);

  // R3
  id_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_IDENT && data_oe_o && addr_q == ADDR_W'(0)) |-> data_o == ID_MFR);

  // R2
  hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic        vpp = 1'b1;
  logic [7:0]  dout;
  logic        doe, er_act, pg_act;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk_i(clk), .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .addr_i(addr), .data_i(din), .vpp_hi_i(vpp),
    .data_o(dout), .data_oe_o(doe),
    .erase_active_o(er_act), .prog_active_o(pg_act)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d, input bit sel = 1'b1);
    @(negedge clk);
    addr = a; din = d; ce_ni = ~sel;
    repeat (3) @(negedge clk);
    we_ni = 1'b0;
    repeat (4) @(negedge clk);
    we_ni = 1'b1;
    repeat (4) @(negedge clk);
    ce_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [17:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ce_ni = 1'b0; oe_ni = 1'b0;
    repeat (6) @(negedge clk);
    d = dout; oe = doe;
    ce_ni = 1'b1; oe_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [17:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic oe;
    rd(a, d, oe);
    chk(req, {7'd0, oe}, 8'd1);
    chk(req, d, exp);
  endtask

  initial begin
    logic [7:0] img [16];
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe", {7'd0, doe}, 8'd0);
    chk("R1 erase", {7'd0, er_act}, 8'd0);
    chk("R1 prog", {7'd0, pg_act}, 8'd0);
    for (int i = 0; i < 16; i++) begin rd_chk("R1", 18'(i), 8'hFF); img[i] = 8'hFF; end

    // R2 output disabled when oe high
    @(negedge clk); ce_ni = 1'b0; oe_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 hiz oe", {7'd0, doe}, 8'd0);
    chk("R2 hiz data", dout, 8'h00);
    ce_ni = 1'b1; oe_ni = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 hiz ce", {7'd0, doe}, 8'd0);
    oe_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R3 identifier
    wr(18'h0, 8'h90);
    rd_chk("R3 mfr", 18'h0, 8'h89);
    rd_chk("R3 dev", 18'h1, 8'hBD);
    rd_chk("R3 other", 18'h2, 8'h00);
    rd_chk("R3 high addr", 18'h10, 8'h00);
    rd_chk("R3 persist", 18'h0, 8'h89);
    wr(18'h0, 8'hFF);

    // R6 R7 program sweep
    for (int i = 0; i < 16; i++) begin
      wr(18'h0, 8'h40);
      wr(18'(i), pat(i));
      chk("R6 prog active", {7'd0, pg_act}, 8'd1);
      img[i] = img[i] & pat(i);
      wr(18'(15 - i), 8'hC0);
      chk("R7 prog stop", {7'd0, pg_act}, 8'd0);
      rd_chk("R7 verify", 18'(15 - i), img[i]);
      wr(18'h0, 8'hFF);
    end
    for (int i = 0; i < 16; i++) rd_chk("R2 sweep", 18'(i), img[i]);

    // R6 second program only clears bits
    wr(18'h0, 8'h40); wr(18'h3, 8'hF0); wr(18'h0, 8'hC0); wr(18'h0, 8'h00);
    img[3] = img[3] & 8'hF0;
    rd_chk("R6 and", 18'h3, img[3]);

    // R8 no voltage
    vpp = 1'b0;
    wr(18'h0, 8'h40); wr(18'h5, 8'h00);
    chk("R8 no prog", {7'd0, pg_act}, 8'd0);
    rd_chk("R8 prog unchanged", 18'h5, img[5]);
    wr(18'h0, 8'h20); wr(18'h0, 8'h20);
    chk("R8 no erase", {7'd0, er_act}, 8'd0);
    rd_chk("R8 erase unchanged", 18'h0, img[0]);
    vpp = 1'b1;

    // R9 rejected / aborted sequences
    wr(18'h0, 8'h20); wr(18'h0, 8'h55);
    chk("R9 setup abort", {7'd0, er_act}, 8'd0);
    rd_chk("R9 setup abort read", 18'h7, img[7]);
    wr(18'h0, 8'h90); wr(18'h0, 8'h12);
    rd_chk("R9 unknown byte", 18'h0, img[0]);
    wr(18'h0, 8'h40); wr(18'h8, 8'hFF); wr(18'h0, 8'h33);
    chk("R9 prog abort", {7'd0, pg_act}, 8'd0);
    rd_chk("R9 prog abort read", 18'h1, img[1]);

    // R10 deselected writes
    wr(18'h0, 8'h90, 1'b0);
    rd_chk("R10 ignored id", 18'h0, img[0]);
    wr(18'h0, 8'h20, 1'b0); wr(18'h0, 8'h20, 1'b0);
    chk("R10 ignored erase", {7'd0, er_act}, 8'd0);
    rd_chk("R10 array kept", 18'h2, img[2]);

    // R4 R5 erase and verify
    wr(18'h0, 8'h20); wr(18'h0, 8'h20);
    chk("R4 erase active", {7'd0, er_act}, 8'd1);
    wr(18'h9, 8'hA0);
    chk("R5 erase stop", {7'd0, er_act}, 8'd0);
    rd_chk("R5 verify", 18'h2, 8'hFF);
    wr(18'h0, 8'hFF);
    for (int i = 0; i < 16; i++) rd_chk("R4 erased", 18'(i), 8'hFF);

    // R5 latched verify address ignores read address
    wr(18'h0, 8'h40); wr(18'h9, 8'h3C); wr(18'h0, 8'hC0); wr(18'h0, 8'hFF);
    wr(18'h9, 8'hA0);
    rd_chk("R5 latched", 18'h0, 8'h3C);
    rd_chk("R5 latched other", 18'h4, 8'h3C);
    wr(18'h0, 8'hFF);

    // R9 erase ended by a non-verify byte
    wr(18'h0, 8'h20); wr(18'h0, 8'h20);
    chk("R9 erase on", {7'd0, er_act}, 8'd1);
    wr(18'h0, 8'h77);
    chk("R9 erase abort", {7'd0, er_act}, 8'd0);
    rd_chk("R9 erase abort read", 18'h9, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule